// File: doc/BRIEF.md
# Battery Charge Bar-Graph Display Controller

This block drives a four-segment LED bar graph that shows how much charge is left in a battery. It takes a relative state-of-charge value in percent, a signed charge current in milliamps, a display-control input with three states, and a strobe that pulses once per second. It produces four active-high segment enables that fill from segment 0 upward, like a thermometer.

The control input is already decoded into three states, and each state selects a display mode. Driven high blanks the display. Driven low starts a one-shot that keeps the display lit for four strobe periods. Floating lights the display only while the battery charges faster than a fixed threshold. The block only decides whether the display is lit and how many segments to show. It does not measure charge.

Top module: `charge_bar_ctrl`

## Requirements
- R1: When the display is lit, segment i (0..3) is on exactly when the clamped state of charge is above 25*i percent. So 0% lights none, 1–25% lights seg_o[0] only, and 76–100% lights all four.
- R2: A state-of-charge value above 100 gives the same segments as 100.
- R3: With disp_mode_i equal to 2'b10 (driven high) or 2'b11 (reserved, handled as high), seg_o is 4'b0000 in the same cycle, whatever the other inputs are.
- R4: With disp_mode_i equal to 2'b00 (floating) and the timer idle, the display is lit only while current_i, read as two's complement, is greater than +100. Values of +100 and below, including negative values, leave it dark.
- R5: When disp_mode_i changes to 2'b01 (driven low) from any other code, the display is lit from the next clock edge on. It goes dark at the clock edge that samples the fourth tick_i pulse after the entry cycle. A tick in the entry cycle itself is not counted.
- R6: A new change to 2'b01 while the timer is running restarts the four-tick count.
- R7: Driving the control high while the timer runs cancels the timer. A later floating state with slow current then stays dark.
- R8: While rst_ni is low, seg_o is 4'b0000 and the timer is cleared. After reset, a floating state with slow current is dark.
- R9: A running timer keeps counting and keeps the display lit when the control changes from low to floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soc_i | input | 8 | Relative state of charge, percent |
| current_i | input | 16 | Signed charge current, mA, positive means charging |
| disp_mode_i | input | 2 | 00 floating, 01 driven low, 10 driven high, 11 reserved |
| tick_i | input | 1 | One-cycle pulse each second |
| seg_o | output | 4 | Segment enables, active high |

## Verification
Two things can fall in the same cycle: the start of the one-shot and a one-second tick. The bench provokes this by switching the control to low in the very cycle that carries a tick. It then confirms that the display stays lit through three more ticks and goes dark on the fourth, so the coinciding tick was not counted. A second case blanks the display with a high control in a cycle that carries a tick. The bench checks that seg_o is dark in that cycle and that the cancelled timer does not light the display afterwards.

// File: rtl/charge_bar_pkg.sv
package charge_bar_pkg;
  typedef enum logic [1:0] {
    DISP_FLOAT = 2'b00,
    DISP_LOW   = 2'b01,
    DISP_HIGH  = 2'b10,
    DISP_RSVD  = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/bar_level.sv
module bar_level #(
  parameter int SOC_W    = 8,
  parameter int NUM_SEG  = 4,
  parameter int FULL_PCT = 100
) (
  input  logic [SOC_W-1:0]   soc_i,
  output logic [NUM_SEG-1:0] bar_o
);
  localparam int STEP = FULL_PCT / NUM_SEG;
  localparam logic [SOC_W-1:0] FULL = SOC_W'(FULL_PCT);

  logic [SOC_W-1:0] soc_c;
  assign soc_c = (soc_i > FULL) ? FULL : soc_i;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [SOC_W-1:0] TH = SOC_W'(i * STEP);
    assign bar_o[i] = soc_c > TH;
  end

  // R1
  always_comb begin
    bar_thermo_chk: assert (((bar_o + 1'b1) & bar_o) == '0);
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R5
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && tick_i && cnt_q == LAST && !start_i && !cancel_i) |=> !active_q);
  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cancel_i) |=> (active_q && cnt_q == '0));
  // R7
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !active_q);
  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R8
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> cnt_q == '0);
endmodule

// File: rtl/charge_bar_ctrl.sv
module charge_bar_ctrl
  import charge_bar_pkg::*;
#(
  parameter int SOC_W      = 8,
  parameter int CUR_W      = 16,
  parameter int NUM_SEG    = 4,
  parameter int FULL_PCT   = 100,
  parameter int FAST_MA    = 100,
  parameter int HOLD_TICKS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SOC_W-1:0]        soc_i,
  input  logic signed [CUR_W-1:0] current_i,
  input  logic [1:0]              disp_mode_i,
  input  logic                    tick_i,
  output logic [NUM_SEG-1:0]      seg_o
);
  localparam logic signed [CUR_W-1:0] FAST_TH = CUR_W'(FAST_MA);

  disp_mode_e mode;
  logic is_low, is_high, is_float, low_q, start, fast, active, lit;
  logic [NUM_SEG-1:0] bar;

  assign mode     = disp_mode_e'(disp_mode_i);
  assign is_low   = mode == DISP_LOW;
  assign is_float = mode == DISP_FLOAT;
  assign is_high  = (mode == DISP_HIGH) || (mode == DISP_RSVD);
  assign fast     = current_i > FAST_TH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 1'b0;
    else         low_q <= is_low;
  end

  assign start = is_low && !low_q;

  oneshot_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cancel_i(is_high),
    .tick_i  (tick_i),
    .active_o(active)
  );

  bar_level #(.SOC_W(SOC_W), .NUM_SEG(NUM_SEG), .FULL_PCT(FULL_PCT)) u_bar (
    .soc_i(soc_i),
    .bar_o(bar)
  );

  assign lit   = rst_ni && !is_high && (active || (is_float && fast));
  assign seg_o = lit ? bar : '0;

  // R3
  high_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_high |-> seg_o == '0);
  // R4
  float_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_float && !fast && !active) |-> seg_o == '0);
  // R5
  low_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !is_high) |=> (is_high || seg_o == bar));
endmodule

// File: tb/charge_bar_ctrl_tb.sv
`timescale 1ns/1ps
module charge_bar_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] soc = 8'd0;
  logic signed [15:0] cur = 16'sd0;
  logic [1:0] mode = 2'b00;
  logic tick = 1'b0;
  logic [3:0] seg;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  charge_bar_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soc_i(soc), .current_i(cur),
    .disp_mode_i(mode), .tick_i(tick), .seg_o(seg)
  );

  function automatic logic [3:0] exp_bar(int s);
    int c = (s > 100) ? 100 : s;
    int n = (c + 24) / 25;
    return 4'((1 << n) - 1);
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    total++;
    if (seg !== exp) begin
      bad++;
      $display("FAIL %s seg=%b exp=%b", req, seg, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick_step();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    soc = 8'd80; cur = 16'sd500; mode = 2'b00;
    #1; chk("R8 in reset", 4'b0000);
    step(); step(); rst_n = 1'b1; #1;
    chk("R8 after release fast float", exp_bar(80));
    cur = 16'sd0; #1; chk("R8 idle timer slow float", 4'b0000);

    // R1 R2: sweep full SOC range in fast floating mode
    cur = 16'sd200;
    for (int s = 0; s < 256; s++) begin
      soc = 8'(s); #1;
      chk(s > 100 ? "R2 clamp" : "R1 level", exp_bar(s));
    end

    // R4 threshold sweep
    soc = 8'd60;
    for (int c = -300; c <= 300; c += 50) begin
      cur = 16'(c); #1;
      chk("R4 float rate", (c > 100) ? exp_bar(60) : 4'b0000);
    end
    cur = 16'sd100; #1; chk("R4 at 100", 4'b0000);
    cur = 16'sd101; #1; chk("R4 at 101", exp_bar(60));
    cur = -16'sd32768; #1; chk("R4 most negative", 4'b0000);

    // R3 high and reserved blank
    cur = 16'sd1000;
    for (int m = 2; m < 4; m++) begin
      for (int s = 0; s <= 100; s += 20) begin
        mode = 2'(m); soc = 8'(s); #1;
        chk("R3 blank", 4'b0000);
      end
    end
    step();

    // R5 one-shot
    cur = 16'sd0; soc = 8'd60; mode = 2'b01; #1;
    chk("R5 entry same cycle dark", 4'b0000);
    step(); chk("R5 lit after entry", exp_bar(60));
    step(); step(); chk("R5 lit without ticks", exp_bar(60));
    for (int k = 1; k <= 3; k++) begin
      tick_step(); chk("R5 lit before 4th tick", exp_bar(60));
    end
    tick_step(); chk("R5 dark at 4th tick", 4'b0000);
    step(); chk("R5 stays dark while low", 4'b0000);

    // R5 coincidence: entry with a tick in the same cycle
    mode = 2'b00; step();
    mode = 2'b01; tick = 1'b1; step(); tick = 1'b0;
    chk("R5 coincident entry lit", exp_bar(60));
    for (int k = 1; k <= 3; k++) begin
      tick_step(); chk("R5 coincident tick not counted", exp_bar(60));
    end
    tick_step(); chk("R5 coincident expiry", 4'b0000);

    // R6 restart + R9 float continues the timer
    mode = 2'b00; step();
    mode = 2'b01; step();
    tick_step(); tick_step();
    mode = 2'b00; step(); chk("R9 float keeps timer lit", exp_bar(60));
    mode = 2'b01; step(); chk("R6 re-entry lit", exp_bar(60));
    for (int k = 1; k <= 3; k++) begin
      tick_step(); chk("R6 restarted count lit", exp_bar(60));
    end
    tick_step(); chk("R6 restarted expiry", 4'b0000);

    // R7 high cancels, coinciding with a tick
    mode = 2'b00; step();
    mode = 2'b01; step(); chk("R7 timer running", exp_bar(60));
    mode = 2'b10; tick = 1'b1; #1; chk("R7 blank at once", 4'b0000);
    step(); tick = 1'b0;
    mode = 2'b00; #1; chk("R7 cancelled float dark", 4'b0000);
    step(); step(); chk("R7 still dark", 4'b0000);

    // R8 reset mid-timer
    mode = 2'b01; step(); step(); chk("R8 timer running", exp_bar(60));
    rst_n = 1'b0; #1; chk("R8 reset blanks", 4'b0000);
    mode = 2'b00; step(); rst_n = 1'b1; #1;
    chk("R8 timer cleared", 4'b0000);
    step(); chk("R8 still cleared", 4'b0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule